// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block holds the program counter of a single-cycle 32-bit core and works out where execution goes next. The counter is kept as a 30-bit word address, so byte-address bits 1:0 are never stored. Each cycle the block receives the control fields that a decoder has already produced: a branch kind, a PC source select, a 26-bit jump field, a 16-bit branch offset and the two register operands. It presents the next word address combinationally. On the next rising clock edge it loads that address into the counter.

A single adder with an implicit carry of one forms the sequential address. A branch-condition checker decides whether the sign-extended offset is added into that sum. A four-way source select then chooses among four candidates: the sequential or branch sum, a region-relative jump target, a register target, and a fixed system-call entry word. The sequential sum is also exported so that a jump-and-link can write it to the link register.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_word` becomes 0 after that edge.
- R2: With `br_kind` = 00 and `pc_src` = 00, `pc_next` equals `pc_word` + 1, wrapping modulo 2^30 (word 0x3FFFFFFF is followed by 0).
- R3: `br_kind` = 01 takes the branch exactly when `rs_val` equals `rt_val`. A taken branch yields `pc_word` + 1 + the sign-extended `br_offset`, so a negative offset moves backwards.
- R4: `br_kind` = 10 takes the branch exactly when `rs_val` differs from `rt_val`.
- R5: `br_kind` = 11 takes the branch exactly when bit 31 of `rs_val` is 1. `rt_val` has no influence.
- R6: A branch that is not taken yields `pc_word` + 1 at `pc_next` when `pc_src` = 00.
- R7: `pc_src` = 01 gives `pc_next` = {`pc_word`[29:26], `jump_field`}.
- R8: `pc_src` = 10 gives `pc_next` = `rs_val`[31:2]. Bits 1:0 of `rs_val` are dropped.
- R9: `pc_src` = 11 gives `pc_next` = the parameter `SYSCALL_WADDR`.
- R10: `seq_word` equals `pc_word` + 1 whenever no branch is taken, whatever `pc_src` is. It equals the branch target when a branch is taken.
- R11: When `rst` is low, each rising edge loads `pc_next` into `pc_word`.
- R12: When `pc_src` is not 00, a taken branch condition has no effect on `pc_next`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| jump_field | input | 26 | Word-address field of a direct jump |
| br_offset | input | 16 | Signed branch offset in words |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| br_kind | input | 2 | 00 none, 01 if equal, 10 if different, 11 if rs negative |
| pc_src | input | 2 | 00 sequential/branch, 01 jump, 10 register, 11 system call |
| pc_word | output | 30 | Current program counter (word address) |
| pc_next | output | 30 | Address to be loaded at the next edge |
| seq_word | output | 30 | Sequential or branch sum, used as link value |

## Verification
The bench keeps the 32-bit data width and sets `SYSCALL_WADDR` to 0x25A5A5A5. That value has bits set across the whole word, so a mis-wired or truncated system-call vector shows up at once. The counter is steered to the top word 0x3FFFFFFF to expose the wrap of the increment. It is also steered to an address with upper bits 1010, so a jump target that fails to keep the region bits from the counter is caught. Negative and positive offsets reach both sign cases of the offset extension.

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter int DW = 32,
  parameter int JW = 26,
  parameter int OW = 16,
  parameter logic [DW-3:0] SYSCALL_WADDR = 'h100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [JW-1:0] jump_field,
  input  logic [OW-1:0] br_offset,
  input  logic [DW-1:0] rs_val,
  input  logic [DW-1:0] rt_val,
  input  logic [1:0]    br_kind,
  input  logic [1:0]    pc_src,
  output logic [DW-3:0] pc_word,
  output logic [DW-3:0] pc_next,
  output logic [DW-3:0] seq_word
);
  localparam int AW = DW - 2;

  logic          taken;
  logic [AW-1:0] addend;

  always_comb begin
    unique case (br_kind)
      2'b01:   taken = (rs_val == rt_val);
      2'b10:   taken = (rs_val != rt_val);
      2'b11:   taken = rs_val[DW-1];
      default: taken = 1'b0;
    endcase
  end

  assign addend   = taken ? {{(AW-OW){br_offset[OW-1]}}, br_offset} : '0;
  assign seq_word = pc_word + addend + AW'(1);

  always_comb begin
    unique case (pc_src)
      2'b00:   pc_next = seq_word;
      2'b01:   pc_next = {pc_word[AW-1:JW], jump_field};
      2'b10:   pc_next = rs_val[DW-1:2];
      default: pc_next = SYSCALL_WADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_word <= '0;
    else     pc_word <= pc_next;
  end
endmodule

// File: rtl/next_pc_unit_chk.sv
module next_pc_unit_chk #(
  parameter int DW = 32,
  parameter logic [DW-3:0] SYSCALL_WADDR = 'h100
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] rs_val,
  input logic [DW-1:0] rt_val,
  input logic [1:0]    br_kind,
  input logic [1:0]    pc_src,
  input logic [DW-3:0] pc_word,
  input logic [DW-3:0] pc_next,
  input logic [DW-3:0] seq_word
);
  localparam int AW = DW - 2;

  a_r1_sync_reset: assert property (@(posedge clk) rst |=> pc_word == '0);

  a_r11_pc_loads: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pc_word == $past(pc_next));

  a_r10_link_plain: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'b00) |-> seq_word == pc_word + AW'(1));

  a_r4_bne_equal: assert property (@(posedge clk) disable iff (rst)
    (pc_src == 2'b00 && br_kind == 2'b10 && rs_val == rt_val) |-> pc_next == pc_word + AW'(1));

  a_r5_bltz_clear: assert property (@(posedge clk) disable iff (rst)
    (pc_src == 2'b00 && br_kind == 2'b11 && !rs_val[DW-1]) |-> pc_next == pc_word + AW'(1));

  a_r8_reg_target: assert property (@(posedge clk) disable iff (rst)
    (pc_src == 2'b10) |-> pc_next == rs_val[DW-1:2]);

  a_r9_syscall: assert property (@(posedge clk) disable iff (rst)
    (pc_src == 2'b11) |-> pc_next == SYSCALL_WADDR);
endmodule

bind next_pc_unit next_pc_unit_chk #(.DW(DW), .SYSCALL_WADDR(SYSCALL_WADDR)) u_chk (
  .clk(clk), .rst(rst), .rs_val(rs_val), .rt_val(rt_val), .br_kind(br_kind),
  .pc_src(pc_src), .pc_word(pc_word), .pc_next(pc_next), .seq_word(seq_word)
);

// File: tb/tb_next_pc_unit.sv
module tb_next_pc_unit;
  localparam logic [29:0] SYS = 30'h25A5A5A5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [25:0] jump_field = '0;
  logic [15:0] br_offset = '0;
  logic [31:0] rs_val = '0, rt_val = '0;
  logic [1:0]  br_kind = 2'b00, pc_src = 2'b00;
  logic [29:0] pc_word, pc_next, seq_word;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  next_pc_unit #(.SYSCALL_WADDR(SYS)) dut (
    .clk(clk), .rst(rst), .jump_field(jump_field), .br_offset(br_offset),
    .rs_val(rs_val), .rt_val(rt_val), .br_kind(br_kind), .pc_src(pc_src),
    .pc_word(pc_word), .pc_next(pc_next), .seq_word(seq_word)
  );

  task automatic check(input string req, input logic [29:0] act, input logic [29:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic load_pc(input logic [29:0] w);
    br_kind = 2'b00; pc_src = 2'b10; rs_val = {w, 2'b00};
    tick();
    check("R11 load", pc_word, w);
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick();
    check("R1 reset", pc_word, 30'h0);
    rst = 1'b0;
  endtask

  task automatic t_seq();
    load_pc(30'h00001234);
    br_kind = 2'b00; pc_src = 2'b00; settle();
    check("R2 next", pc_next, 30'h00001235);
    check("R10 seq", seq_word, 30'h00001235);
    tick();
    check("R11 step", pc_word, 30'h00001235);
  endtask

  task automatic t_wrap();
    load_pc(30'h3FFFFFFF);
    br_kind = 2'b00; pc_src = 2'b00; settle();
    check("R2 wrap", pc_next, 30'h0);
  endtask

  task automatic t_beq();
    load_pc(30'd100);
    pc_src = 2'b00; br_kind = 2'b01; br_offset = 16'hFFFB;
    rs_val = 32'd5; rt_val = 32'd5; settle();
    check("R3 beq back", pc_next, 30'd96);
    rt_val = 32'd6; settle();
    check("R6 beq not", pc_next, 30'd101);
    rt_val = 32'd5; br_offset = 16'h0010; settle();
    check("R3 beq fwd", pc_next, 30'd117);
    tick();
    check("R11 beq", pc_word, 30'd117);
  endtask

  task automatic t_bne();
    load_pc(30'd200);
    pc_src = 2'b00; br_kind = 2'b10; br_offset = 16'h0008;
    rs_val = 32'd1; rt_val = 32'd2; settle();
    check("R4 bne taken", pc_next, 30'd209);
    rt_val = 32'd1; settle();
    check("R4 bne not", pc_next, 30'd201);
  endtask

  task automatic t_bltz();
    load_pc(30'd300);
    pc_src = 2'b00; br_kind = 2'b11; br_offset = 16'h0020;
    rs_val = 32'h80000000; rt_val = 32'h80000000; settle();
    check("R5 bltz taken", pc_next, 30'd333);
    rs_val = 32'h7FFFFFFF; rt_val = 32'h0; settle();
    check("R5 bltz not", pc_next, 30'd301);
    check("R10 seq not", seq_word, 30'd301);
  endtask

  task automatic t_jump();
    load_pc(30'h28000000);
    pc_src = 2'b01; br_kind = 2'b00; jump_field = 26'h0123456; settle();
    check("R7 jump", pc_next, 30'h28123456);
    check("R10 link", seq_word, 30'h28000001);
  endtask

  task automatic t_jr();
    load_pc(30'd7);
    pc_src = 2'b10; br_kind = 2'b00; rs_val = 32'h12345677; settle();
    check("R8 jr", pc_next, 30'h048D159D);
  endtask

  task automatic t_sys();
    load_pc(30'd5);
    pc_src = 2'b11; br_kind = 2'b01; rs_val = 32'd9; rt_val = 32'd9; br_offset = 16'h0040; settle();
    check("R9 sys", pc_next, SYS);
    check("R3 seq taken", seq_word, 30'd70);
    tick();
    check("R12 sys load", pc_word, SYS);
  endtask

  task automatic t_ignore();
    load_pc(30'h00000010);
    pc_src = 2'b01; jump_field = 26'h3FFFFFF; br_kind = 2'b01;
    rs_val = 32'd3; rt_val = 32'd3; br_offset = 16'h0100; settle();
    check("R12 ignore", pc_next, 30'h03FFFFFF);
  endtask

  task automatic t_midreset();
    pc_src = 2'b11; rst = 1'b1; tick();
    check("R1 mid reset", pc_word, 30'h0);
    rst = 1'b0; pc_src = 2'b00; br_kind = 2'b00;
  endtask

  initial begin
    #3;
    t_reset();
    t_seq();
    t_wrap();
    t_beq();
    t_bne();
    t_bltz();
    t_jump();
    t_jr();
    t_sys();
    t_ignore();
    t_midreset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule